// File: doc/BRIEF.md
# Double-Buffered HDLC Receive Byte Pool

This block holds received bytes for a serial HDLC-style receiver. Its 64 bytes of storage form two 32-byte halves that trade places. One half collects bytes from the receiver shift register. The other half belongs to the host processor, which reads it through a 32-location window. The address bits inside that window are not decoded, so every read returns the next byte in arrival order.

When the collecting half is full and the host holds no half, the two halves swap on the next clock edge. The full half then belongs to the host, and a pool-full interrupt goes high if it is enabled. The host empties that half and hands it back with a release strobe. If the collecting half is already full at that point, the next swap follows at once. A receiver-reset command empties both halves and clears the sticky error flags.

Top module: `rx_pingpong_fifo`

## Requirements
- R1: After `rst`, `irq_rpf`, `ovf_flag`, `unr_flag` and `host_rvalid` are 0, no half is held by the host, and bytes are first collected into half 0.
- R2: Accepted bytes fill the collecting half in order. Once it holds 32 bytes and the host holds no half, the halves swap on the next clock edge and the full half becomes the host's half.
- R3: A `host_rd` pulse that hits an unread byte of the host's half gives `host_rvalid` = 1 and that byte on `host_rdata` one cycle later. Successive reads return the bytes in the order they arrived.
- R4: `host_addr` has no effect on read data: any value from 0x00 to 0x1F returns the same next byte.
- R5: `irq_rpf` is 1 exactly when `irq_en` was 1 at the last edge and the host holds a half after that edge. With `irq_en` = 0 it stays 0.
- R6: The halves never swap while the host holds a half. A `host_release` pulse hands the half back, and a full collecting half then swaps on the following edge.
- R7: A byte that arrives while the collecting half is full and the host holds a half is dropped and never read. It sets `ovf_flag`, which stays 1 until a reset.
- R8: A read with no unread byte left, or with no half held, gives `host_rvalid` = 1 with `host_rdata` = 0x00. It sets `unr_flag`, which stays 1 until a reset.
- R9: `rx_rst_cmd` returns the block to its reset state from R1 and discards all stored bytes.
- R10: A byte that arrives on the very edge where the halves swap is kept as the first byte of the new collecting half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_rst_cmd | input | 1 | Receiver reset command; clears buffer state and flags |
| sr_valid | input | 1 | A byte from the shift register is present |
| sr_data | input | 8 | Byte from the shift register |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 5 | Host address inside the read window (not decoded) |
| host_release | input | 1 | Host hands back its half |
| irq_en | input | 1 | Enables the pool-full interrupt |
| host_rdata | output | 8 | Read data, valid when host_rvalid is 1 |
| host_rvalid | output | 1 | Read data strobe, one cycle after host_rd |
| irq_rpf | output | 1 | Pool-full interrupt (level) |
| ovf_flag | output | 1 | Sticky overflow: a byte was dropped |
| unr_flag | output | 1 | Sticky underrun: a read found no byte |

## Verification
Two situations are the hardest to reach from the ports. The first is a byte arriving on exactly the edge where the halves swap. The second is a byte arriving while both halves are busy. The directed part reaches the first by streaming more than 32 bytes without a gap while the host holds nothing, so the 33rd byte falls on the swap edge. It reaches the second by filling the second half before the host releases the first. After that, the random phase mixes sparse releases and rare receiver resets with a per-edge model of both halves, so that swaps, drops and underruns occur in many different orders.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  typedef enum logic {HALF0 = 1'b0, HALF1 = 1'b1} half_t;

  function automatic half_t other_half(half_t h);
    return (h == HALF0) ? HALF1 : HALF0;
  endfunction
endpackage

// File: rtl/rxpp_bank.sv
module rxpp_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/rxpp_ctrl.sv
module rxpp_ctrl
  import rxpp_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_rst_cmd,
  input  logic          sr_valid,
  input  logic          host_rd,
  input  logic          host_release,
  input  logic          irq_en,
  output logic          wr_en,
  output half_t         wr_half,
  output logic [AW-1:0] wr_addr,
  output logic          rd_ok,
  output half_t         host_half,
  output logic [AW-1:0] rd_addr,
  output half_t         rd_half_q,
  output logic          rvalid_q,
  output logic          zero_q,
  output logic          irq_q,
  output logic          ovf_q,
  output logic          unr_q
);
  half_t         fill_sel;
  logic [CW-1:0] fill_cnt;
  logic [CW-1:0] rd_ptr;
  logic          busy;
  logic          full, swap_now, accept, drop;

  assign full      = (fill_cnt == CW'(DEPTH));
  assign swap_now  = full && !busy;
  assign accept    = sr_valid && (swap_now || !full);
  assign drop      = sr_valid && full && busy;
  assign host_half = other_half(fill_sel);
  assign wr_en     = accept;
  assign wr_half   = swap_now ? other_half(fill_sel) : fill_sel;
  assign wr_addr   = swap_now ? '0 : fill_cnt[AW-1:0];
  assign rd_ok     = host_rd && busy && (rd_ptr < CW'(DEPTH));
  assign rd_addr   = rd_ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst || rx_rst_cmd) begin
      fill_sel  <= HALF0;
      fill_cnt  <= '0;
      rd_ptr    <= '0;
      busy      <= 1'b0;
      irq_q     <= 1'b0;
      ovf_q     <= 1'b0;
      unr_q     <= 1'b0;
      rvalid_q  <= 1'b0;
      zero_q    <= 1'b1;
      rd_half_q <= HALF1;
    end else begin
      if (swap_now) begin
        fill_sel <= other_half(fill_sel);
        fill_cnt <= accept ? CW'(1) : '0;
        busy     <= 1'b1;
        rd_ptr   <= '0;
      end else begin
        if (accept)       fill_cnt <= fill_cnt + CW'(1);
        if (host_release) busy     <= 1'b0;
        if (rd_ok)        rd_ptr   <= rd_ptr + CW'(1);
      end
      irq_q     <= irq_en && (swap_now || (busy && !host_release));
      ovf_q     <= ovf_q || drop;
      unr_q     <= unr_q || (host_rd && !rd_ok);
      rvalid_q  <= host_rd;
      zero_q    <= !rd_ok;
      rd_half_q <= host_half;
    end
  end

  // R2: fill count never exceeds one half
  p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CW'(DEPTH));

  // R6: no swap while the host still holds its half
  p_no_swap_while_held_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !host_release && !rx_rst_cmd) |=> $stable(fill_sel));

  // R7: a byte arriving into a blocked pool raises the overflow flag
  p_drop_sets_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    (sr_valid && full && busy && !rx_rst_cmd) |=> ovf_q);

  // R7: overflow is sticky
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !rx_rst_cmd) |=> ovf_q);

  // R8: underrun is sticky
  p_unr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (unr_q && !rx_rst_cmd) |=> unr_q);

  // R5: interrupt stays low without enable
  p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq_q);
endmodule

// File: rtl/rx_pingpong_fifo.sv
module rx_pingpong_fifo
  import rxpp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int NHALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_rst_cmd,
  input  logic              sr_valid,
  input  logic [DATA_W-1:0] sr_data,
  input  logic              host_rd,
  input  logic [AW-1:0]     host_addr,
  input  logic              host_release,
  input  logic              irq_en,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              irq_rpf,
  output logic              ovf_flag,
  output logic              unr_flag
);
  logic          wr_en, rd_ok, rvalid_q, zero_q;
  half_t         wr_half, host_half, rd_half_q;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [NHALF-1:0]       wr_b, rd_b;
  logic [DATA_W-1:0]      bank_q [NHALF];

  rxpp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .rx_rst_cmd(rx_rst_cmd),
    .sr_valid(sr_valid), .host_rd(host_rd), .host_release(host_release),
    .irq_en(irq_en), .wr_en(wr_en), .wr_half(wr_half), .wr_addr(wr_addr),
    .rd_ok(rd_ok), .host_half(host_half), .rd_addr(rd_addr),
    .rd_half_q(rd_half_q), .rvalid_q(rvalid_q), .zero_q(zero_q),
    .irq_q(irq_rpf), .ovf_q(ovf_flag), .unr_q(unr_flag)
  );

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    assign wr_b[g] = wr_en && (wr_half == half_t'(g));
    assign rd_b[g] = rd_ok && (host_half == half_t'(g));

    rxpp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .wr_en(wr_b[g]), .wr_addr(wr_addr), .wr_data(sr_data),
      .rd_en(rd_b[g]), .rd_addr(rd_addr), .rd_data(bank_q[g])
    );

    // R2: the collecting half and the host half are never the same bank
    p_banks_disjoint_r2: assert property (@(posedge clk) disable iff (rst)
      !(wr_b[g] && rd_b[g]));
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = (rvalid_q && !zero_q) ? bank_q[rd_half_q] : '0;

  // R8: a read without a byte returns zero and flags underrun
  p_underrun_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !rd_ok && !rx_rst_cmd) |=> (host_rvalid && host_rdata == '0 && unr_flag));

  // R4: window address is a defined value whenever a read is issued
  p_addr_known_r4: assert property (@(posedge clk) disable iff (rst)
    host_rd |-> !$isunknown(host_addr));
endmodule

// File: tb/test_rx_pingpong_fifo.sv
module test_rx_pingpong_fifo;
  logic       clk = 1'b0;
  logic       rst, rx_rst_cmd, sr_valid, host_rd, host_release, irq_en;
  logic [7:0] sr_data;
  logic [4:0] host_addr;
  logic [7:0] host_rdata;
  logic       host_rvalid, irq_rpf, ovf_flag, unr_flag;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  byte unsigned fq[$];
  byte unsigned hq[$];
  bit  held;
  int  rdi;
  bit  m_ovf, m_unr, m_irq, m_rv;
  byte unsigned m_d;

  always #4 clk = ~clk;

  rx_pingpong_fifo i_rx_pingpong_fifo (
    .clk(clk), .rst(rst), .rx_rst_cmd(rx_rst_cmd), .sr_valid(sr_valid),
    .sr_data(sr_data), .host_rd(host_rd), .host_addr(host_addr),
    .host_release(host_release), .irq_en(irq_en), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .irq_rpf(irq_rpf), .ovf_flag(ovf_flag),
    .unr_flag(unr_flag)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_clear();
    fq.delete(); hq.delete();
    held = 0; rdi = 0; m_ovf = 0; m_unr = 0; m_irq = 0; m_rv = 0; m_d = 0;
  endfunction

  function automatic void model_edge(bit v, byte unsigned d, bit rd, bit rel, bit en);
    bit sw;
    sw = (fq.size() == 32) && !held;
    m_rv = rd;
    m_d  = 0;
    if (rd) begin
      if (held && rdi < 32) begin m_d = hq[rdi]; rdi++; end
      else m_unr = 1;
    end
    if (sw) begin
      hq = fq; fq.delete(); held = 1; rdi = 0;
      if (v) fq.push_back(d);
    end else begin
      if (v) begin
        if (fq.size() < 32) fq.push_back(d);
        else m_ovf = 1;
      end
      if (rel) held = 0;
    end
    m_irq = en && held;
  endfunction

  // one clock: drive at negedge, apply the model at posedge, check at next negedge
  task automatic cyc(bit v, byte unsigned d, bit rd, logic [4:0] a, bit rel, bit rr, string tag);
    sr_valid = v; sr_data = d; host_rd = rd; host_addr = a;
    host_release = rel; rx_rst_cmd = rr;
    @(posedge clk);
    if (rr) model_clear();
    else model_edge(v, d, rd, rel, irq_en);
    @(negedge clk);
    chk(host_rvalid == m_rv, "R3", "rvalid", host_rvalid, m_rv);
    if (m_rv) chk(host_rdata == m_d, tag, "rdata", host_rdata, m_d);
    chk(irq_rpf == m_irq, "R5", "irq", irq_rpf, m_irq);
    chk(ovf_flag == m_ovf, "R7", "ovf", ovf_flag, m_ovf);
    chk(unr_flag == m_unr, "R8", "unr", unr_flag, m_unr);
  endtask

  task automatic send(byte unsigned d);  cyc(1, d, 0, 0, 0, 0, "R2"); endtask
  task automatic idle();                 cyc(0, 0, 0, 0, 0, 0, "R2"); endtask
  task automatic rd1(string tag);        cyc(0, 0, 1, 5'($urandom), 0, 0, tag); endtask
  task automatic rel1();                 cyc(0, 0, 0, 0, 1, 0, "R6"); endtask

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    rst = 1; rx_rst_cmd = 0; sr_valid = 0; sr_data = 0; host_rd = 0;
    host_addr = 0; host_release = 0; irq_en = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(!irq_rpf && !ovf_flag && !unr_flag && !host_rvalid, "R1", "reset flags",
        {irq_rpf, ovf_flag, unr_flag, host_rvalid}, 0);
    rd1("R8");                       // R8: read with no half held
    cyc(0, 0, 0, 0, 0, 1, "R9");     // R9: receiver reset clears underrun
    chk(unr_flag == 0, "R9", "unr after rx reset", unr_flag, 0);

    irq_en = 1;
    for (int i = 0; i < 32; i++) send(8'($urandom));
    idle();                          // R2: swap edge
    chk(irq_rpf == 1, "R2", "swap after full half", irq_rpf, 1);
    // second half fills while host holds the first, then R7 drops
    for (int i = 0; i < 36; i++) send(8'($urandom));
    chk(ovf_flag == 1, "R7", "overflow after drop", ovf_flag, 1);
    for (int i = 0; i < 32; i++) rd1("R4");  // R3 R4: order with random window address
    rd1("R8");                               // R8: past the end
    rel1();                                  // R6: release, then swap
    idle();
    chk(irq_rpf == 1, "R6", "second half presented", irq_rpf, 1);
    for (int i = 0; i < 32; i++) rd1("R7");  // R7: dropped bytes absent
    rel1();
    idle();
    chk(irq_rpf == 0, "R5", "irq low when nothing held", irq_rpf, 0);

    // R10: continuous stream across the swap edge
    cyc(0, 0, 0, 0, 0, 1, "R9");
    for (int i = 0; i < 40; i++) send(8'($urandom));
    for (int i = 0; i < 32; i++) rd1("R10");
    rel1();
    for (int i = 0; i < 30; i++) send(8'($urandom));
    idle();
    for (int i = 0; i < 8; i++) rd1("R10");  // starts with the swap-edge byte

    irq_en = 0;                              // R5: disabled interrupt
    rel1();
    for (int i = 0; i < 40; i++) send(8'($urandom));
    chk(irq_rpf == 0, "R5", "irq with enable low", irq_rpf, 0);

    // R9: reset mid-fill
    cyc(0, 0, 0, 0, 0, 1, "R9");
    chk(!irq_rpf && !ovf_flag && !unr_flag, "R9", "flags after rx reset",
        {irq_rpf, ovf_flag, unr_flag}, 0);
    rd1("R9");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 64 == 0) irq_en = ~irq_en;
      cyc(($urandom % 2) == 1, 8'($urandom), ($urandom % 3) == 0, 5'($urandom),
          ($urandom % 40) == 0, ($urandom % 700) == 0, "R3");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule